// File: doc/BRIEF.md
# Machine-Cycle Sampled Reset Generator

This block turns a raw, asynchronous, active-high reset pin into the internal reset controls of a core whose machine cycle spans twelve oscillator periods. A free-running period counter divides each machine cycle into six states of two phases. The synchronised pin is looked at only once per machine cycle, in state 5 phase 2. The block then drives three outputs: an internal reset level, a load strobe that tells the special registers to take their initial contents, and a delayed enable that forces the port pins into their reset condition. The initial contents are all ones for the port latches, 07H for the stack pointer and zero for the other special registers. The serial data buffer and internal RAM keep their contents.

A small state machine holds the sequence. Its states are ST_RUN (normal operation), ST_ARMED (one high sample seen, internal reset active), ST_VALID (a second consecutive high sample has confirmed a valid reset) and ST_FORCED (the port hold delay has run out and the ports are forced). The transitions are: ST_RUN to ST_ARMED on a high sample. ST_ARMED to ST_VALID on a high sample, which issues the load strobe. ST_ARMED to ST_RUN on a low sample. ST_VALID to ST_FORCED when the hold delay expires. ST_VALID or ST_FORCED to ST_RUN on a low sample. A power-on input `por_n` clears the counters and the state machine to a known starting point.

Top module: `mc_reset_gen`

## Requirements
- R1: Each clock is one oscillator period. A period index counts 0 to 11 and wraps. It is brought out as `mc_state` = index/2 + 1 (values 1..6) and `mc_phase` = index mod 2 + 1 (values 1..2). While `por_n` is low the index is 0, which shows state 1 phase 1.
- R2: The pin passes through a two-flop synchroniser. It is sampled only at the clock edge that ends period index 9 (state 5, phase 2). A pin level takes effect at that edge only if it was applied at least three edges earlier. A high pulse whose synchronised image misses every sample edge has no effect on any output.
- R3: `rst_int` rises in the clock that follows the first high sample.
- R4: `rst_int` stays high while samples stay high. It falls in the clock after the first low sample, and `port_force` falls in the same clock.
- R5: `sfr_load` is a one-clock pulse in the clock after a second consecutive high sample, which is 12 periods after the first. A lone high sample produces no pulse.
- R6: `port_force` rises 19 periods after the first high sample, provided the second sample was high. It stays high until the first low sample.
- R7: After `por_n` is released, `rst_int`, `port_force` and `sfr_load` are low until a high sample arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one period per tick |
| por_n | input | 1 | Active-low power-on clear of counters and state |
| rst_pin | input | 1 | Raw asynchronous active-high reset pin |
| rst_int | output | 1 | Internal reset level |
| port_force | output | 1 | Forces port pins to their reset state |
| sfr_load | output | 1 | One-clock strobe loading special-register initial values |
| mc_state | output | 3 | Current machine state, 1..6 |
| mc_phase | output | 2 | Current phase, 1..2 |

## Verification
The hardest situations to reach are the ones that hinge on where a pin edge falls relative to the single sample slot, once the synchroniser delay is counted. These are a pulse that lands just inside or just outside the slot, and a pin held high for exactly one or exactly two samples. The stimulus places every pin transition at a computed offset from the sample edge, derived from the bench's own period count. It sweeps both the lead time before the first sample and the tail after the last high sample, so the boundary cases of one, two and many high samples and the ignored glitch are all hit on purpose.

// File: rtl/mcrst_pkg.sv
package mcrst_pkg;

    // Reset sequencer states
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ARMED  = 2'd1,
        ST_VALID  = 2'd2,
        ST_FORCED = 2'd3
    } rst_state_t;

    // Initial values applied by consumers of the load strobe
    localparam logic [7:0] PORT_LATCH_INIT = 8'hFF;
    localparam logic [7:0] STACK_PTR_INIT  = 8'h07;
    localparam logic [7:0] OTHER_SFR_INIT  = 8'h00;

endpackage

// File: rtl/mcrst_timebase.sv
module mcrst_timebase #(
    parameter int PERIODS      = 12,
    parameter int SAMPLE_STATE = 5,
    parameter int SAMPLE_PHASE = 2
) (
    input  logic                         clk,
    input  logic                         por_n,
    output logic                         sample_tick,
    output logic [2:0]                   state_num,
    output logic [1:0]                   phase_num
);
    localparam int PW   = $clog2(PERIODS);
    localparam int SLOT = (SAMPLE_STATE - 1) * 2 + (SAMPLE_PHASE - 1);

    logic [PW-1:0] period_idx;
    logic [PW-1:0] half_idx;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            period_idx <= '0;
        end else if (period_idx == PW'(PERIODS - 1)) begin
            period_idx <= '0;
        end else begin
            period_idx <= period_idx + PW'(1);
        end
    end

    always_comb begin
        half_idx    = period_idx >> 1;
        state_num   = 3'(half_idx) + 3'd1;
        phase_num   = period_idx[0] ? 2'd2 : 2'd1;
        sample_tick = (period_idx == PW'(SLOT));
    end

    // R1
    period_range_chk: assert property (@(posedge clk) disable iff (!por_n)
        period_idx <= PW'(PERIODS - 1));

    // R1
    period_wrap_chk: assert property (@(posedge clk) disable iff (!por_n)
        (period_idx == PW'(PERIODS - 1)) |=> (state_num == 3'd1 && phase_num == 2'd1));

endmodule

// File: rtl/mcrst_sync.sv
module mcrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge por_n) begin
                    if (!por_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(sync_out) |-> $past(chain[0]));

endmodule

// File: rtl/mcrst_fsm.sv
module mcrst_fsm
    import mcrst_pkg::*;
#(
    parameter int HOLD_PERIODS = 19,
    parameter int PERIODS      = 12
) (
    input  logic clk,
    input  logic por_n,
    input  logic sample_tick,
    input  logic pin_sync,
    output logic rst_int,
    output logic port_force,
    output logic sfr_load
);
    localparam int HW = $clog2(HOLD_PERIODS + 1);

    rst_state_t    state_q, state_d;
    logic [HW-1:0] hold_cnt;
    logic          hold_done;

    assign hold_done = (hold_cnt == HW'(HOLD_PERIODS));

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (sample_tick && pin_sync) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (sample_tick) state_d = pin_sync ? ST_VALID : ST_RUN;
            end
            ST_VALID: begin
                if (sample_tick && !pin_sync) state_d = ST_RUN;
                else if (hold_done)           state_d = ST_FORCED;
            end
            ST_FORCED: begin
                if (sample_tick && !pin_sync) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // State register and hold counter
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q  <= ST_RUN;
            hold_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) begin
                hold_cnt <= (state_d == ST_ARMED) ? HW'(1) : '0;
            end else if ((state_q == ST_ARMED || state_q == ST_VALID) && !hold_done) begin
                hold_cnt <= hold_cnt + HW'(1);
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sfr_load <= 1'b0;
        else        sfr_load <= (state_q == ST_ARMED) && (state_d == ST_VALID);
    end

    assign rst_int    = (state_q != ST_RUN);
    assign port_force = (state_q == ST_FORCED);

    // R4
    rst_tick_chk: assert property (@(posedge clk) disable iff (!por_n)
        (rst_int != $past(rst_int)) |-> $past(sample_tick));

    // R5
    load_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        sfr_load |=> !sfr_load);

    // R5
    load_confirm_chk: assert property (@(posedge clk) disable iff (!por_n)
        sfr_load |-> (rst_int && $past(sample_tick) && $past(pin_sync)));

    // R6
    force_delay_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(port_force) |-> ($past(hold_cnt) == HW'(HOLD_PERIODS)));

    initial begin
        hold_vs_cycle_chk: assert (HOLD_PERIODS > PERIODS);
    end

endmodule

// File: rtl/mc_reset_gen.sv
module mc_reset_gen #(
    parameter int PERIODS      = 12,
    parameter int SAMPLE_STATE = 5,
    parameter int SAMPLE_PHASE = 2,
    parameter int SYNC_STAGES  = 2,
    parameter int HOLD_PERIODS = 19
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_pin,
    output logic       rst_int,
    output logic       port_force,
    output logic       sfr_load,
    output logic [2:0] mc_state,
    output logic [1:0] mc_phase
);
    logic tick;
    logic pin_s;

    mcrst_timebase #(
        .PERIODS      (PERIODS),
        .SAMPLE_STATE (SAMPLE_STATE),
        .SAMPLE_PHASE (SAMPLE_PHASE)
    ) u_timebase (
        .clk         (clk),
        .por_n       (por_n),
        .sample_tick (tick),
        .state_num   (mc_state),
        .phase_num   (mc_phase)
    );

    mcrst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .async_in (rst_pin),
        .sync_out (pin_s)
    );

    mcrst_fsm #(
        .HOLD_PERIODS (HOLD_PERIODS),
        .PERIODS      (PERIODS)
    ) u_fsm (
        .clk         (clk),
        .por_n       (por_n),
        .sample_tick (tick),
        .pin_sync    (pin_s),
        .rst_int     (rst_int),
        .port_force  (port_force),
        .sfr_load    (sfr_load)
    );

    // R7
    quiet_after_por_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(rst_int) |-> $past(tick));

endmodule

// File: tb/mc_reset_gen_tb_top.sv
module mc_reset_gen_tb_top;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_pin = 1'b0;
    logic       rst_int, port_force, sfr_load;
    logic [2:0] mc_state;
    logic [1:0] mc_phase;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    typedef struct {
        int    at;
        bit    r;
        bit    f;
        bit    l;
        string tag;
    } exp_t;

    exp_t q[$];

    always #10 clk = ~clk;   // 50 MHz

    mc_reset_gen dut_i (
        .clk        (clk),
        .por_n      (por_n),
        .rst_pin    (rst_pin),
        .rst_int    (rst_int),
        .port_force (port_force),
        .sfr_load   (sfr_load),
        .mc_state   (mc_state),
        .mc_phase   (mc_phase)
    );

    always @(posedge clk) if (por_n) cyc <= cyc + 1;

    // Monitor: timebase each cycle, output changes against scoreboard
    bit pr = 0, pf = 0, pl = 0;
    always @(negedge clk) begin
        if (por_n && !done) begin
            tests++;
            if (mc_state != 3'((cyc % 12) / 2 + 1) || mc_phase != 2'(cyc % 2 + 1)) begin
                fails++;
                $display("FAIL R1 cyc=%0d state/phase=%0d/%0d expected %0d/%0d",
                         cyc, mc_state, mc_phase, (cyc % 12) / 2 + 1, cyc % 2 + 1);
            end
            if (rst_int != pr || port_force != pf || sfr_load != pl) begin
                tests++;
                if (q.size() == 0) begin
                    fails++;
                    $display("FAIL R2 unexpected change cyc=%0d r/f/l=%0b%0b%0b expected %0b%0b%0b",
                             cyc, rst_int, port_force, sfr_load, pr, pf, pl);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (e.at != cyc || e.r != rst_int || e.f != port_force || e.l != sfr_load) begin
                        fails++;
                        $display("FAIL %s cyc=%0d r/f/l=%0b%0b%0b expected cyc=%0d r/f/l=%0b%0b%0b",
                                 e.tag, cyc, rst_int, port_force, sfr_load, e.at, e.r, e.f, e.l);
                    end
                end
                pr = rst_int; pf = port_force; pl = sfr_load;
            end
        end
    end

    task automatic push(input int at, input bit r, input bit f, input bit l, input string tag);
        exp_t e;
        e.at = at; e.r = r; e.f = f; e.l = l; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: pin high for n samples, rising lead cycles from now, falling tail cycles before the last allowed point
    task automatic drive_reset(input int n, input int lead, input int tail);
        int k, e, k2;
        @(negedge clk);
        k = cyc + lead;
        wait_cyc(k);
        rst_pin = 1'b1;
        e = k + 3;
        while (e % 12 != 10) e++;
        push(e, 1, 0, 0, "R3");
        if (n == 1) begin
            push(e + 12, 0, 0, 0, "R5");
        end else begin
            push(e + 12, 1, 0, 1, "R5");
            push(e + 13, 1, 0, 0, "R5");
            push(e + 19, 1, 1, 0, "R6");
            push(e + 12 * n, 0, 0, 0, "R4");
        end
        k2 = e + 12 * n - 3 - tail;
        wait_cyc(k2);
        rst_pin = 1'b0;
        wait_cyc(e + 12 * n + 14);
    endtask

    task automatic check_drained(input string tag);
        tests++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL %s pending events=%0d expected 0", tag, q.size());
            q.delete();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        por_n = 1'b1;
        #1;
        // R7 reset state
        tests++;
        if (rst_int !== 1'b0 || port_force !== 1'b0 || sfr_load !== 1'b0) begin
            fails++;
            $display("FAIL R7 r/f/l=%0b%0b%0b expected 000", rst_int, port_force, sfr_load);
        end
        wait_cyc(30);
        check_drained("R7");

        // R2: one-cycle glitch whose image misses the sample edge
        begin
            int k;
            k = cyc + 1;
            while ((k + 3) % 12 == 10) k++;
            wait_cyc(k);
            rst_pin = 1'b1;
            wait_cyc(k + 1);
            rst_pin = 1'b0;
            wait_cyc(k + 30);
            check_drained("R2");
        end

        // R2/R5: one-cycle glitch landing on the sample edge -> single sample
        begin
            int k;
            k = cyc + 1;
            while ((k + 3) % 12 != 10) k++;
            wait_cyc(k);
            rst_pin = 1'b1;
            push(k + 3, 1, 0, 0, "R2");
            push(k + 15, 0, 0, 0, "R5");
            wait_cyc(k + 1);
            rst_pin = 1'b0;
            wait_cyc(k + 30);
            check_drained("R5");
        end

        // Sweep leads and tails
        for (int lead = 0; lead < 12; lead += 5) begin
            drive_reset(1, lead, 0);
            check_drained("R5");
            drive_reset(2, lead, 11);
            check_drained("R6");
            drive_reset(4, lead + 1, 6);
            check_drained("R4");
        end
        drive_reset(10, 3, 0);
        check_drained("R4");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        tests++;
        done = 1'b1;
        $display("FAIL watchdog expired at cyc=%0d expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule